// File: doc/BRIEF.md
# Microcoded Accumulator Processor Core

This block is a small accumulator computer. A 128-word by 20-bit control store, held as a constant table, sequences every step. The datapath has an 11-bit program counter and an 11-bit address register. It also has a 16-bit data register, a 16-bit accumulator and a 2048 x 16 main memory kept inside the block. There is no shared bus. Each register loads from a fixed set of multiplexer sources.

Every microword holds three independent 3-bit operation selectors, a 2-bit test selector, a 2-bit next-address mode and a 7-bit target. All three selectors act in the same clock, and each reads register values from before the edge. When two of them write the accumulator in one cycle, the first selector wins over the second and the second over the third. The control store holds an instruction fetch routine at word 64 and an indirect-address subroutine at word 67. It also holds routines for four instructions: add to accumulator, branch if negative, store accumulator, and exchange accumulator with memory.

A testbench or host fills main memory through a load port while the core is held. A combinational peek port reads memory back. Raising the load strobe also freezes all core state.

Top module: `ucode_acc_cpu`

## Requirements
- R1: While `rst_n` is low, the control address is 64 and the program counter and accumulator are 0. The first instruction is fetched from word 0.
- R2: Fetch takes three cycles, at control addresses 64, 65 and 66. The program counter rises by one. The next control address is {0, opcode, 00}.
- R3: An instruction word holds the indirect flag in bit 15, the opcode in bits 14..11 and the address in bits 10..0. Opcodes are 0 add, 1 branch, 2 store and 3 exchange.
- R4: Add with the flag clear sets AC to AC + M[addr], modulo 2^16. It takes 3 cycles after fetch, then control returns to address 64.
- R5: With the indirect flag set, the effective address is bits 10..0 of M[addr]. The indirect subroutine adds exactly 2 cycles, and control resumes at the word after the call.
- R6: Branch with AC bit 15 clear takes 2 cycles and leaves PC unchanged. With AC bit 15 set, it takes 3 cycles (5 if indirect) and loads PC with the effective address.
- R7: Store writes AC to M[EA] in 3 cycles (5 if indirect) and leaves AC unchanged.
- R8: Exchange swaps AC and M[EA] in 4 cycles (6 if indirect). Both moves use the values from before the swap.
- R9: While `load_en` is high, the core's control address, PC and AC do not change.
- R10: Opcodes 4 to 15 take one cycle after fetch and change neither AC nor PC. Control then returns to fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_en | input | 1 | Write load_data to memory and hold the core |
| load_addr | input | 11 | Memory load address |
| load_data | input | 16 | Memory load data |
| peek_addr | input | 11 | Memory read-back address |
| peek_data | output | 16 | Memory word at peek_addr (combinational) |
| car_o | output | 7 | Current control address |
| pc_o | output | 11 | Program counter |
| ac_o | output | 16 | Accumulator |

## Verification
Every instruction costs a known number of clocks: 3 for fetch, plus 1 to 6 more that depend on the opcode, the indirect flag and the accumulator sign for branches. The reference model runs the program one instruction at a time and turns those costs into the exact clock count at which the control address next shows 64. At that cycle it compares PC and AC. The bench counts clock edges from the release of reset and samples on the falling edge. On every cycle between two instruction boundaries it checks that the control address is not 64. Memory results are read through the peek port after the core has been frozen with `load_en`.

// File: rtl/ucode_acc_cpu.sv
module ucode_acc_cpu #(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int CW = 7,
  parameter int FETCH_ORG = 64,
  parameter int IND_ORG = 67
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_en,
  input  logic [AW-1:0] load_addr,
  input  logic [DW-1:0] load_data,
  input  logic [AW-1:0] peek_addr,
  output logic [DW-1:0] peek_data,
  output logic [CW-1:0] car_o,
  output logic [AW-1:0] pc_o,
  output logic [DW-1:0] ac_o
);
  localparam int WORDS = 1 << AW;
  localparam int UW = 9 + 4 + CW;

  localparam logic [2:0] A_ADD = 3'd1, A_CLR = 3'd2, A_INC = 3'd3, A_DR2AC = 3'd4,
                         A_DR2AR = 3'd5, A_PC2AR = 3'd6, A_WR = 3'd7;
  localparam logic [2:0] B_SUB = 3'd1, B_OR = 3'd2, B_AND = 3'd3, B_RD = 3'd4,
                         B_AC2DR = 3'd5, B_INCDR = 3'd6, B_PC2DR = 3'd7;
  localparam logic [2:0] C_XOR = 3'd1, C_COM = 3'd2, C_SHL = 3'd3, C_SHR = 3'd4,
                         C_INCPC = 3'd5, C_AR2PC = 3'd6;
  localparam logic [1:0] T_ONE = 2'd0, T_IND = 2'd1, T_NEG = 2'd2, T_ZERO = 2'd3;
  localparam logic [1:0] N_JMP = 2'd0, N_CALL = 2'd1, N_RET = 2'd2, N_MAP = 2'd3;
  localparam logic [CW-1:0] FETCH = CW'(FETCH_ORG);
  localparam logic [CW-1:0] INDR  = CW'(IND_ORG);

  logic [DW-1:0] mem [WORDS];
  logic [CW-1:0] car, sbr, car_n;
  logic [AW-1:0] pc, ar, pc_n, ar_n;
  logic [DW-1:0] dr, ac, dr_n, ac_n, mrd;
  logic [UW-1:0] uw;
  logic [2:0]    f1, f2, f3;
  logic [1:0]    tsel, nmode;
  logic [CW-1:0] tgt;
  logic          tst, run;

  function automatic logic [UW-1:0] mw(logic [2:0] a, logic [2:0] b, logic [2:0] c,
                                        logic [1:0] t, logic [1:0] n, logic [CW-1:0] d);
    return {a, b, c, t, n, d};
  endfunction

  always_comb begin
    case (car)
      7'd0:    uw = mw(3'd0, 3'd0, 3'd0, T_IND, N_CALL, INDR);
      7'd1:    uw = mw(3'd0, B_RD, 3'd0, T_ONE, N_JMP, 7'd2);
      7'd2:    uw = mw(A_ADD, 3'd0, 3'd0, T_ONE, N_JMP, FETCH);
      7'd4:    uw = mw(3'd0, 3'd0, 3'd0, T_NEG, N_JMP, 7'd6);
      7'd6:    uw = mw(3'd0, 3'd0, 3'd0, T_IND, N_CALL, INDR);
      7'd7:    uw = mw(3'd0, 3'd0, C_AR2PC, T_ONE, N_JMP, FETCH);
      7'd8:    uw = mw(3'd0, 3'd0, 3'd0, T_IND, N_CALL, INDR);
      7'd9:    uw = mw(3'd0, B_AC2DR, 3'd0, T_ONE, N_JMP, 7'd10);
      7'd10:   uw = mw(A_WR, 3'd0, 3'd0, T_ONE, N_JMP, FETCH);
      7'd12:   uw = mw(3'd0, 3'd0, 3'd0, T_IND, N_CALL, INDR);
      7'd13:   uw = mw(3'd0, B_RD, 3'd0, T_ONE, N_JMP, 7'd14);
      7'd14:   uw = mw(A_DR2AC, B_AC2DR, 3'd0, T_ONE, N_JMP, 7'd15);
      7'd15:   uw = mw(A_WR, 3'd0, 3'd0, T_ONE, N_JMP, FETCH);
      7'd64:   uw = mw(A_PC2AR, 3'd0, 3'd0, T_ONE, N_JMP, 7'd65);
      7'd65:   uw = mw(3'd0, B_RD, C_INCPC, T_ONE, N_JMP, 7'd66);
      7'd66:   uw = mw(A_DR2AR, 3'd0, 3'd0, T_ONE, N_MAP, 7'd0);
      7'd67:   uw = mw(3'd0, B_RD, 3'd0, T_ONE, N_JMP, 7'd68);
      7'd68:   uw = mw(A_DR2AR, 3'd0, 3'd0, T_ONE, N_RET, 7'd0);
      default: uw = mw(3'd0, 3'd0, 3'd0, T_ONE, N_JMP, FETCH);
    endcase
  end

  assign {f1, f2, f3, tsel, nmode, tgt} = uw;
  assign run = !load_en;
  assign mrd = mem[ar];
  assign peek_data = mem[peek_addr];
  assign car_o = car;
  assign pc_o = pc;
  assign ac_o = ac;

  always_comb begin
    case (tsel)
      T_ONE:   tst = 1'b1;
      T_IND:   tst = dr[DW-1];
      T_NEG:   tst = ac[DW-1];
      default: tst = (ac == '0);
    endcase
  end

  // R3: the opcode sits in dr[14:11] and selects the routine start {0, op, 00}
  always_comb begin
    case (nmode)
      N_JMP, N_CALL: car_n = tst ? tgt : car + 1'b1;
      N_RET:         car_n = sbr;
      default:       car_n = {1'b0, dr[DW-2:DW-5], 2'b00};
    endcase
  end

  always_comb begin
    ac_n = ac;
    case (f3)
      C_XOR:   ac_n = ac ^ dr;
      C_COM:   ac_n = ~ac;
      C_SHL:   ac_n = {ac[DW-2:0], 1'b0};
      C_SHR:   ac_n = {1'b0, ac[DW-1:1]};
      default: ;
    endcase
    case (f2)
      B_SUB:   ac_n = ac - dr;
      B_OR:    ac_n = ac | dr;
      B_AND:   ac_n = ac & dr;
      default: ;
    endcase
    case (f1)
      A_ADD:   ac_n = ac + dr;
      A_CLR:   ac_n = '0;
      A_INC:   ac_n = ac + 1'b1;
      A_DR2AC: ac_n = dr;
      default: ;
    endcase
  end

  always_comb begin
    case (f2)
      B_RD:    dr_n = mrd;
      B_AC2DR: dr_n = ac;
      B_INCDR: dr_n = dr + 1'b1;
      B_PC2DR: dr_n = {dr[DW-1:AW], pc};
      default: dr_n = dr;
    endcase
  end

  assign ar_n = (f1 == A_DR2AR) ? dr[AW-1:0] : (f1 == A_PC2AR) ? pc : ar;
  assign pc_n = (f3 == C_INCPC) ? pc + 1'b1 : (f3 == C_AR2PC) ? ar : pc;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      car <= FETCH;
      sbr <= '0;
      pc  <= '0;
      ar  <= '0;
      dr  <= '0;
      ac  <= '0;
    end else if (run) begin
      car <= car_n;
      if (nmode == N_CALL && tst) sbr <= car + 1'b1;
      pc  <= pc_n;
      ar  <= ar_n;
      dr  <= dr_n;
      ac  <= ac_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load_en) mem[load_addr] <= load_data;
    else if (rst_n && f1 == A_WR) mem[ar] <= dr;
  end
endmodule

// File: rtl/ucode_acc_chk.sv
module ucode_acc_chk #(
  parameter int AW = 11,
  parameter int DW = 16,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          hold,
  input logic [CW-1:0] car,
  input logic [CW-1:0] sbr,
  input logic [AW-1:0] pc,
  input logic [AW-1:0] ar,
  input logic [DW-1:0] ac
);
  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car == 7'd64 && !hold) |=> car == 7'd65);

  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car == 7'd65 && !hold) |=> pc == AW'($past(pc) + 1'b1));

  // R2
  map_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car == 7'd66 && !hold) |=> (car[CW-1] == 1'b0 && car[1:0] == 2'b00));

  // R5
  ind_return_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car == 7'd68 && !hold) |=> car == $past(sbr));

  // R6
  branch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (car == 7'd7 && !hold) |=> pc == $past(ar));

  // R9
  hold_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> ($stable(car) && $stable(pc) && $stable(ac)));
endmodule

bind ucode_acc_cpu ucode_acc_chk #(.AW(AW), .DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .hold(load_en), .car(car), .sbr(sbr),
  .pc(pc), .ar(ar), .ac(ac)
);

// File: tb/tb_ucode_acc_cpu.sv
`timescale 1ns/1ps
module tb_ucode_acc_cpu;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic load_en = 1'b0;
  logic [10:0] load_addr = '0;
  logic [15:0] load_data = '0;
  logic [10:0] peek_addr = '0;
  logic [15:0] peek_data;
  logic [6:0]  car_o;
  logic [10:0] pc_o;
  logic [15:0] ac_o;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [15:0] mm [2048];
  int    q_cyc[$];
  int    q_pc[$];
  int    q_ac[$];
  string q_tag[$];

  always #4 clk = ~clk;

  ucode_acc_cpu dut (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_addr(load_addr),
    .load_data(load_data), .peek_addr(peek_addr), .peek_data(peek_data),
    .car_o(car_o), .pc_o(pc_o), .ac_o(ac_o)
  );

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #800000;
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  // Behavioural reference: one instruction at a time, with its clock cost
  task automatic build_model(input int ninst);
    logic [10:0] pc = '0;
    logic [15:0] ac = '0;
    int cyc = 0;
    for (int i = 0; i < ninst; i++) begin
      logic [15:0] w = mm[pc];
      logic ind = w[15];
      logic [3:0] op = w[14:11];
      logic [10:0] ea = w[15] ? mm[w[10:0]][10:0] : w[10:0];
      logic [15:0] t;
      int len = 3;
      string tag;
      pc = pc + 1'b1;
      case (op)
        4'd0: begin ac = ac + mm[ea]; len += 3 + 2 * ind; tag = ind ? "R5" : "R3 R4"; end
        4'd1: begin
          if (!ac[15]) begin len += 2; tag = "R6"; end
          else begin pc = ea; len += 3 + 2 * ind; tag = ind ? "R5 R6" : "R6"; end
        end
        4'd2: begin mm[ea] = ac; len += 3 + 2 * ind; tag = ind ? "R5 R7" : "R7"; end
        4'd3: begin t = mm[ea]; mm[ea] = ac; ac = t; len += 4 + 2 * ind; tag = ind ? "R5 R8" : "R8"; end
        default: begin len += 1; tag = "R10"; end
      endcase
      cyc += len;
      q_cyc.push_back(cyc); q_pc.push_back(int'(pc)); q_ac.push_back(int'(ac)); q_tag.push_back(tag);
    end
  endtask

  initial begin
    int k;
    int last;
    logic [6:0]  hc;
    logic [10:0] hp;
    logic [15:0] ha;
    for (int a = 0; a < 2048; a++) mm[a] = 16'h0000;
    mm[11'h000] = 16'h0100;            // add 0x100
    mm[11'h001] = 16'h8101;            // add indirect 0x101
    mm[11'h002] = 16'h0810;            // branch, AC positive
    mm[11'h003] = 16'h1103;            // store 0x103
    mm[11'h004] = 16'h1904;            // exchange 0x104
    mm[11'h005] = 16'h9105;            // store indirect 0x105
    mm[11'h006] = 16'h2800;            // opcode 5, unused
    mm[11'h007] = 16'h0810;            // branch taken to 0x10
    mm[11'h010] = 16'h9907;            // exchange indirect 0x107
    mm[11'h011] = 16'h0109;            // add 0x109
    mm[11'h012] = 16'h890A;            // branch indirect 0x10A
    mm[11'h020] = 16'h010B;            // add, wraps to 0
    mm[11'h021] = 16'h0800;            // branch, AC zero
    mm[11'h022] = 16'h110C;            // store 0x10C
    mm[11'h023] = 16'h7800;            // opcode 15, unused
    mm[11'h100] = 16'h0005;
    mm[11'h101] = 16'h0102;
    mm[11'h102] = 16'h0003;
    mm[11'h104] = 16'h8001;
    mm[11'h105] = 16'h0106;
    mm[11'h107] = 16'h0108;
    mm[11'h109] = 16'h8000;
    mm[11'h10A] = 16'h0020;
    mm[11'h10B] = 16'h8000;
    mm[11'h10C] = 16'h1234;

    @(negedge clk);
    load_en = 1'b1;
    for (int a = 0; a < 2048; a++) begin
      load_addr = 11'(a);
      load_data = mm[a];
      @(negedge clk);
    end
    load_en = 1'b0;
    @(negedge clk);
    // R1
    chk("R1", int'(car_o), 64, "car in reset");
    chk("R1", int'(pc_o), 0, "pc in reset");
    chk("R1", int'(ac_o), 0, "ac in reset");

    build_model(15);
    rst_n = 1'b1;
    // R1: boundary 0, before any run edge
    chk("R1", int'(car_o), 64, "car after release");
    k = 0;
    last = q_cyc[q_cyc.size() - 1];
    while (q_cyc.size() > 0) begin
      @(negedge clk);
      k++;
      if (k == q_cyc[0]) begin
        string tg = q_tag.pop_front();
        void'(q_cyc.pop_front());
        chk(tg, int'(car_o), 64, "car at boundary");
        chk(tg, int'(pc_o), q_pc.pop_front(), "pc at boundary");
        chk(tg, int'(ac_o), q_ac.pop_front(), "ac at boundary");
        if (k == last) begin
          load_en = 1'b1;
          load_addr = 11'h7FF;
          load_data = 16'h0000;
        end
      end else begin
        chk("R2", int'(car_o == 7'd64), 0, "car reached fetch between boundaries");
      end
    end

    // R9: core frozen under load_en
    hc = car_o; hp = pc_o; ha = ac_o;
    repeat (5) @(negedge clk);
    chk("R9", int'(car_o), int'(hc), "car held");
    chk("R9", int'(pc_o), int'(hp), "pc held");
    chk("R9", int'(ac_o), int'(ha), "ac held");

    for (int a = 16'h100; a <= 16'h10C; a++) begin
      peek_addr = 11'(a);
      #1;
      chk("R7 R8", int'(peek_data), int'(mm[a]), $sformatf("mem[%0h]", a));
    end
    finish_run();
  end
endmodule